// File: doc/BRIEF.md
# Atomic Sequence and Reservation Admission Gate

This gate sits in front of a cache sequencer's request tables and decides, cycle by cycle, whether an incoming request may be admitted. It enforces exclusive servicing of atomic read-modify-write sequences. The first admitted atomic read takes an ownership lock for the requesting processor ID. While that lock is held, requests from every other processor are refused. A nesting counter tracks how many atomic reads are still waiting for their matching atomic write. The lock is released when the count returns to zero.

The gate also keeps a single load-linked / store-conditional reservation for this sequencer. When a locked read completes, the gate records a reservation on that line. A locked write is checked against the reservation at issue. On a match, the reservation is consumed and the write goes ahead. With no matching reservation, the write is not issued and the failure flag is raised for the caller, who reports failure code minus two. Completions of atomic reads and atomic writes produce one-cycle notifications to the cache controller.

Admission decisions are combinational from the request inputs and the current state. State and completion pulses update on the rising clock edge. Request kinds are encoded on 3 bits:
- 0 load
- 1 instruction fetch
- 2 store
- 3 atomic read
- 4 atomic write
- 5 locked read
- 6 locked write

The processor ID of all ones is reserved to mean "no owner".

Top module: `atomic_gate`

## Requirements
- R1: After reset, no lock is held: `lock_held`=0 and `lock_owner` is all ones. No completion pulse is active, and no reservation exists, so a locked write is flagged as failed.
- R2: While a lock is held, any request whose processor ID differs from the owner has `req_allow`=0 and `req_issue`=0. Requests of any kind from the owner are allowed.
- R3: An atomic read (kind 3) admitted with no owner makes its processor the owner. Each admitted atomic read adds one to the nesting count.
- R4: An admitted atomic write (kind 4) from the owner reduces the count by one. When the count reaches zero, the lock is released and `lock_owner` returns to all ones.
- R5: Three cases are refused: an atomic write while no owner exists, an atomic read while the count is at its maximum, and an atomic read from the reserved all-ones ID.
- R6: Completion of a locked read (kind 5) sets the reservation to that line. A later locked-read completion overwrites the older one.
- R7: A locked write (kind 6) to the reserved line is allowed and issued, and it consumes the reservation, so a second locked write to that line fails.
- R8: A locked write without a matching reservation gives `req_allow`=1, `sc_fail`=1 and `req_issue`=0. Nothing is allocated downstream, and any reservation on another line is left intact.
- R9: One cycle after an atomic-read completion, `set_atomic` pulses with `set_line` equal to the completed line. One cycle after an atomic-write completion, `clr_atomic` pulses. Completions of other kinds pulse neither.
- R10: With no owner, loads, fetches, stores and locked reads are allowed and issued without changing the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request presented this cycle |
| req_kind | input | 3 | Request kind code |
| req_pid | input | PID_W | Requesting processor ID |
| req_line | input | LINE_W | Request line address |
| req_allow | output | 1 | Request passes the lock check |
| req_issue | output | 1 | Request is to be allocated and sent |
| sc_fail | output | 1 | Locked write refused for lack of reservation |
| cmp_valid | input | 1 | Completion presented this cycle |
| cmp_kind | input | 3 | Completion kind code |
| cmp_line | input | LINE_W | Completion line address |
| set_atomic | output | 1 | Pulse: atomic read completed |
| set_line | output | LINE_W | Line for set_atomic |
| clr_atomic | output | 1 | Pulse: atomic write completed |
| lock_held | output | 1 | An owner holds the atomic lock |
| lock_owner | output | PID_W | Owner ID, all ones when idle |

## Verification
The bench builds the gate with a 2-bit nesting counter, a 3-bit processor ID and 8-bit lines. With a 2-bit counter, the saturation refusal is reached after only three nested atomic reads. With a 3-bit ID, the reserved all-ones ID 7 can be driven directly. The directed scenarios cover:
- reservation overwrite and consumption
- failed locked writes that leave a reservation on another line intact
- the release of the lock exactly at a count of zero

// File: rtl/atomic_gate.sv
module atomic_gate #(
  parameter int PID_W  = 4,
  parameter int LINE_W = 26,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [LINE_W-1:0] req_line,
  output logic              req_allow,
  output logic              req_issue,
  output logic              sc_fail,
  input  logic              cmp_valid,
  input  logic [2:0]        cmp_kind,
  input  logic [LINE_W-1:0] cmp_line,
  output logic              set_atomic,
  output logic [LINE_W-1:0] set_line,
  output logic              clr_atomic,
  output logic              lock_held,
  output logic [PID_W-1:0]  lock_owner
);
  localparam logic [PID_W-1:0] NO_OWNER = '1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [2:0] K_ARD = 3'd3;
  localparam logic [2:0] K_AWR = 3'd4;
  localparam logic [2:0] K_LL  = 3'd5;
  localparam logic [2:0] K_SC  = 3'd6;

  logic [PID_W-1:0]  owner_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              resv_v_q;
  logic [LINE_W-1:0] resv_line_q;

  logic held, foreign, is_ard, is_awr, is_sc, bad_awr, bad_ard, resv_hit;

  assign held     = owner_q != NO_OWNER;
  assign foreign  = held && (req_pid != owner_q);
  assign is_ard   = req_kind == K_ARD;
  assign is_awr   = req_kind == K_AWR;
  assign is_sc    = req_kind == K_SC;
  assign bad_awr  = is_awr && !held;
  assign bad_ard  = is_ard && ((cnt_q == CNT_MAX) || (req_pid == NO_OWNER));
  assign resv_hit = resv_v_q && (resv_line_q == req_line);

  assign req_allow  = req_valid && !foreign && !bad_awr && !bad_ard;
  assign sc_fail    = req_allow && is_sc && !resv_hit;
  assign req_issue  = req_allow && !sc_fail;
  assign lock_held  = held;
  assign lock_owner = owner_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= NO_OWNER;
      cnt_q   <= '0;
    end else if (req_issue && is_ard) begin
      owner_q <= req_pid;
      cnt_q   <= cnt_q + CNT_ONE;
    end else if (req_issue && is_awr) begin
      cnt_q <= cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) owner_q <= NO_OWNER;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_v_q    <= 1'b0;
      resv_line_q <= '0;
    end else if (cmp_valid && cmp_kind == K_LL) begin
      resv_v_q    <= 1'b1;
      resv_line_q <= cmp_line;
    end else if (req_issue && is_sc) begin
      resv_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_atomic <= 1'b0;
      clr_atomic <= 1'b0;
      set_line   <= '0;
    end else begin
      set_atomic <= cmp_valid && cmp_kind == K_ARD;
      clr_atomic <= cmp_valid && cmp_kind == K_AWR;
      set_line   <= cmp_line;
    end
  end

  // R3 R4
  owner_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == NO_OWNER) == (cnt_q == '0));

  // R2
  foreign_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lock_held && req_pid != lock_owner) |-> !req_allow);

  // R3
  nest_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_issue && req_kind == K_ARD) |=> (cnt_q == $past(cnt_q) + CNT_ONE) && lock_owner == $past(req_pid));

  // R4
  owner_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_held && !(req_issue && req_kind == K_AWR)) |=> $stable(lock_owner));

  // R8
  sc_fail_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fail |-> (!req_issue && req_kind == K_SC));

  // R9
  set_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_kind == K_ARD) |=> (set_atomic && set_line == $past(cmp_line)));

  // R9
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_kind == K_AWR) |=> clr_atomic);
endmodule

// File: tb/atomic_gate_test.sv
module atomic_gate_test;
  localparam int PID_W = 3, LINE_W = 8, CNT_W = 2;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0; logic [2:0] req_kind = 0;
  logic [PID_W-1:0] req_pid = 0; logic [LINE_W-1:0] req_line = 0;
  logic cmp_valid = 0; logic [2:0] cmp_kind = 0; logic [LINE_W-1:0] cmp_line = 0;
  logic req_allow, req_issue, sc_fail, set_atomic, clr_atomic, lock_held;
  logic [LINE_W-1:0] set_line; logic [PID_W-1:0] lock_owner;
  int runs = 0, fails = 0;
  logic a_allow, a_issue, a_fail;

  always #2 clk = ~clk;

  atomic_gate #(.PID_W(PID_W), .LINE_W(LINE_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_pid(req_pid), .req_line(req_line), .req_allow(req_allow),
    .req_issue(req_issue), .sc_fail(sc_fail), .cmp_valid(cmp_valid),
    .cmp_kind(cmp_kind), .cmp_line(cmp_line), .set_atomic(set_atomic),
    .set_line(set_line), .clr_atomic(clr_atomic), .lock_held(lock_held),
    .lock_owner(lock_owner));

  task automatic check(string req, int act, int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int kind, int pid, int line);
    @(negedge clk);
    req_valid = 1; req_kind = 3'(kind); req_pid = PID_W'(pid); req_line = LINE_W'(line);
    #1 a_allow = req_allow; a_issue = req_issue; a_fail = sc_fail;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_op(int kind, int line);
    @(negedge clk);
    cmp_valid = 1; cmp_kind = 3'(kind); cmp_line = LINE_W'(line);
    @(negedge clk);
    cmp_valid = 0;
  endtask

  task automatic t_reset();
    check("R1 held", lock_held, 0);
    check("R1 owner", lock_owner, 7);
    check("R1 pulses", set_atomic | clr_atomic, 0);
    send(6, 1, 8'h10);
    check("R1 sc fails", a_fail, 1);
  endtask

  task automatic t_plain();
    for (int k = 0; k < 6; k++) begin
      if (k == 3 || k == 4) continue;
      send(k, 2, 8'h20 + k);
      check("R10 issue", a_issue, 1);
      check("R10 held", lock_held, 0);
    end
  endtask

  task automatic t_lock();
    send(3, 2, 8'h30);
    check("R3 first", a_issue, 1);
    check("R3 owner", lock_owner, 2);
    send(0, 5, 8'h31);
    check("R2 foreign", a_allow, 0);
    send(2, 2, 8'h32);
    check("R2 owner store", a_issue, 1);
    send(3, 2, 8'h33);
    send(3, 2, 8'h34);
    check("R3 third", a_issue, 1);
    send(3, 2, 8'h35);
    check("R5 full", a_allow, 0);
    send(4, 5, 8'h30);
    check("R2 foreign awr", a_allow, 0);
    send(4, 2, 8'h30); send(4, 2, 8'h33);
    check("R4 still held", lock_owner, 2);
    send(4, 2, 8'h34);
    check("R4 release", lock_held, 0);
    check("R4 owner idle", lock_owner, 7);
  endtask

  task automatic t_bad();
    send(4, 1, 8'h40);
    check("R5 stray awr", a_allow, 0);
    send(3, 7, 8'h41);
    check("R5 reserved id", a_allow, 0);
    check("R5 no lock", lock_held, 0);
  endtask

  task automatic t_resv();
    finish_op(5, 8'h50);
    finish_op(5, 8'h51);
    send(6, 1, 8'h50);
    check("R6 overwritten", a_fail, 1);
    check("R8 allow", a_allow, 1);
    check("R8 no issue", a_issue, 0);
    send(6, 1, 8'h51);
    check("R8 resv kept", a_issue, 1);
    check("R7 ok", a_fail, 0);
    send(6, 1, 8'h51);
    check("R7 consumed", a_fail, 1);
  endtask

  task automatic t_pulses();
    @(negedge clk);
    cmp_valid = 1; cmp_kind = 3; cmp_line = 8'h66;
    @(negedge clk);
    cmp_kind = 4;
    check("R9 set", set_atomic, 1);
    check("R9 line", set_line, 8'h66);
    @(negedge clk);
    cmp_kind = 0;
    check("R9 clr", clr_atomic, 1);
    check("R9 set off", set_atomic, 0);
    @(negedge clk);
    cmp_valid = 0;
    check("R9 none", set_atomic | clr_atomic, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_plain(); t_lock(); t_bad(); t_resv(); t_pulses();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #200000;
    runs++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule